// File: doc/BRIEF.md
# Galloping Pattern Memory Self-Test Engine

This block is a built-in self-test sequencer for a single-port, one-bit-wide synchronous RAM with 2^ADDR_W words. It drives the RAM's address, write enable and write data, then checks each returned read bit against the value it expects. It runs the galloping (ping-pong) test in two background polarities.

In each polarity the engine first fills the array with the background value. It then walks a base cell across every address. For each base cell it does the following:
- writes the inverted background into the base cell;
- interleaves a read of the base cell with a read of each other cell, in ascending order;
- writes the background back into the base cell.

The test takes 4N² + 2N memory cycles, so it suits small arrays or characterisation runs.

A one-cycle `start` pulse launches a run. At the end `done` is high for exactly one cycle, and `pass` is high in that same cycle when no read disagreed. On the first mismatch the engine records three things and keeps them until the next start, while the run continues to its full length:
- the address that was read;
- the base cell in use at that moment;
- the bit it expected.

The RAM port has no back-pressure, so one operation is issued every cycle while the run is active. Read data is taken to return on `mem_rdata` one cycle after the request.

Top module: `galpat_bist`

## Requirements
- R1: After reset `busy`, `done`, `pass`, `fail` and `mem_we` are all 0.
- R2: The first N operations after an accepted start are writes of 0 to addresses 0, 1, …, N-1, in that order.
- R3: With background 0, for each base cell B from 0 to N-1 the engine does the following, one operation per cycle:
  - writes 1 to B;
  - then, for every other address C in ascending order, reads B and then reads C;
  - then writes 0 to B.
- R4: After the last base cell of the background-0 pass, the engine repeats the operations of R2 and R3 with background 1, which swaps every written value.
- R5: `done` rises exactly 4N² + 2N cycles after the cycle in which start was accepted. It is high for one cycle, and `busy` is low in the cycle after it.
- R6: Each read bit is compared one cycle after its request. A base-cell read expects the inverted background, and any other read expects the background. `pass` is 1 at `done` when every comparison matched.
- R7: The first mismatch sets `fail`. It also captures `fail_addr` (the address read), `fail_base` (the base cell at that time) and `fail_exp` (the expected bit). Later mismatches change none of these, and the run still lasts the full count of R5.
- R8: A `start` pulse while `busy` is high has no effect on the schedule or its length. A `start` while idle clears `fail` and the captured values.
- R9: `mem_we` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, taken when idle |
| mem_rdata | input | 1 | RAM read data, one cycle after the request |
| busy | output | 1 | Run in progress, including the done cycle |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | High with done when no mismatch occurred |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatching read |
| fail_base | output | ADDR_W | Base cell at the first mismatch |
| fail_exp | output | 1 | Expected bit at the first mismatch |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 1 | RAM write data |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that `mem_rdata` is a registered RAM response, stable for the whole cycle after its request.

The bench drives `start` for exactly one cycle at a falling edge. Its RAM model registers the read data at the rising edge, so both assumptions hold. That RAM model can inject a stuck-at cell at an address chosen by the seeded random draw or set directly. The bench also pulses `start` once in the middle of a run to show that the pulse is ignored.

// File: rtl/galpat_pkg.sv
package galpat_pkg;
  typedef enum logic [2:0] {
    GP_IDLE,
    GP_FILL,
    GP_SET,
    GP_RD_BASE,
    GP_RD_OTHER,
    GP_RESTORE,
    GP_DONE
  } gp_state_e;
endpackage

// File: rtl/galpat_seq.sv
module galpat_seq
  import galpat_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              clr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_wdata,
  output logic              rd_req,
  output logic              rd_exp,
  output logic [ADDR_W-1:0] base
);
  localparam logic [ADDR_W-1:0] LAST    = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LAST_M1 = LAST - 1'b1;
  localparam logic [ADDR_W-1:0] ONE     = {{(ADDR_W-1){1'b0}}, 1'b1};

  gp_state_e         state;
  logic              bg;
  logic [ADDR_W-1:0] bc;
  logic [ADDR_W-1:0] oc;
  logic [ADDR_W-1:0] oc_inc;
  logic [ADDR_W-1:0] oc_next;
  logic [ADDR_W-1:0] oc_first;
  logic              oc_last;

  // walking "other" cell skips the base cell
  assign oc_inc   = oc + 1'b1;
  assign oc_next  = (oc_inc == bc) ? oc_inc + 1'b1 : oc_inc;
  assign oc_first = (bc == '0) ? ONE : '0;
  assign oc_last  = (oc == LAST) || ((oc == LAST_M1) && (bc == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= GP_IDLE;
      bg    <= 1'b0;
      bc    <= '0;
      oc    <= '0;
    end else begin
      unique case (state)
        GP_IDLE: begin
          if (start) begin
            state <= GP_FILL;
            bg    <= 1'b0;
            oc    <= '0;
          end
        end
        GP_FILL: begin
          if (oc == LAST) begin
            state <= GP_SET;
            bc    <= '0;
          end else begin
            oc <= oc_inc;
          end
        end
        GP_SET: begin
          state <= GP_RD_BASE;
          oc    <= oc_first;
        end
        GP_RD_BASE: state <= GP_RD_OTHER;
        GP_RD_OTHER: begin
          if (oc_last) begin
            state <= GP_RESTORE;
          end else begin
            oc    <= oc_next;
            state <= GP_RD_BASE;
          end
        end
        GP_RESTORE: begin
          if (bc != LAST) begin
            bc    <= bc + 1'b1;
            state <= GP_SET;
          end else if (!bg) begin
            bg    <= 1'b1;
            oc    <= '0;
            state <= GP_FILL;
          end else begin
            state <= GP_DONE;
          end
        end
        GP_DONE: state <= GP_IDLE;
        default: state <= GP_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != GP_IDLE);
    done      = (state == GP_DONE);
    clr       = (state == GP_IDLE) && start;
    mem_we    = (state == GP_FILL) || (state == GP_SET) || (state == GP_RESTORE);
    mem_addr  = ((state == GP_FILL) || (state == GP_RD_OTHER)) ? oc : bc;
    mem_wdata = (state == GP_SET) ? ~bg : bg;
    rd_req    = (state == GP_RD_BASE) || (state == GP_RD_OTHER);
    rd_exp    = (state == GP_RD_BASE) ? ~bg : bg;
    base      = bc;
  end
endmodule

// File: rtl/galpat_cmp.sv
module galpat_cmp #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_req,
  input  logic              rd_exp,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] rd_base,
  input  logic              mem_rdata,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] fail_base,
  output logic              fail_exp
);
  logic              p_vld;
  logic              p_exp;
  logic [ADDR_W-1:0] p_addr;
  logic [ADDR_W-1:0] p_base;
  logic              mism;

  // read data returns one cycle after the request
  assign mism = p_vld && (mem_rdata != p_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld  <= 1'b0;
      p_exp  <= 1'b0;
      p_addr <= '0;
      p_base <= '0;
    end else begin
      p_vld  <= rd_req && !clr;
      p_exp  <= rd_exp;
      p_addr <= rd_addr;
      p_base <= rd_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_base <= '0;
      fail_exp  <= 1'b0;
    end else if (clr) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_base <= '0;
      fail_exp  <= 1'b0;
    end else if (mism && !fail) begin
      fail      <= 1'b1;
      fail_addr <= p_addr;
      fail_base <= p_base;
      fail_exp  <= p_exp;
    end
  end
endmodule

// File: rtl/galpat_bist.sv
module galpat_bist #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] fail_base,
  output logic              fail_exp,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_wdata
);
  logic              clr;
  logic              rd_req;
  logic              rd_exp;
  logic [ADDR_W-1:0] base;

  galpat_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .clr      (clr),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .rd_req   (rd_req),
    .rd_exp   (rd_exp),
    .base     (base)
  );

  galpat_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .rd_req   (rd_req),
    .rd_exp   (rd_exp),
    .rd_addr  (mem_addr),
    .rd_base  (base),
    .mem_rdata(mem_rdata),
    .fail     (fail),
    .fail_addr(fail_addr),
    .fail_base(fail_base),
    .fail_exp (fail_exp)
  );

  assign pass = done && !fail;
endmodule

// File: rtl/galpat_bist_chk.sv
module galpat_bist_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [ADDR_W-1:0] fail_base,
  input logic              fail_exp,
  input logic              mem_we
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R5
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we); // R9
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> fail); // R7
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> ($stable(fail_addr) && $stable(fail_base) && $stable(fail_exp))); // R7
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !fail); // R8
endmodule

bind galpat_bist galpat_bist_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .fail     (fail),
  .fail_addr(fail_addr),
  .fail_base(fail_base),
  .fail_exp (fail_exp),
  .mem_we   (mem_we)
);

// File: tb/tb_galpat_bist.sv
`timescale 1ns/1ps
module tb_galpat_bist;
  localparam int AW = 4;
  localparam int N  = 1 << AW;
  localparam int PH = 2*N*N + N;
  localparam int K  = 2*PH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mem_rdata;
  logic          busy, done, pass, fail, fail_exp, mem_we, mem_wdata;
  logic [AW-1:0] fail_addr, fail_base, mem_addr;

  logic          flt_en = 1'b0;
  int            flt_addr = 0;
  logic          flt_val = 1'b0;
  logic [N-1:0]  ram = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  galpat_bist #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .fail_addr(fail_addr), .fail_base(fail_base), .fail_exp(fail_exp),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  // behavioural RAM with optional stuck-at cell, registered read
  always_ff @(posedge clk) begin
    if (mem_we && !(flt_en && int'(mem_addr) == flt_addr))
      ram[mem_addr] <= mem_wdata;
    mem_rdata <= (flt_en && int'(mem_addr) == flt_addr) ? flt_val : ram[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected operation number i of a run
  task automatic decode_op(input int i, output bit we, output int addr,
                           output bit wd, output int bcv, output bit ex);
    int p, j, k, m, r, pr;
    p = i / PH; j = i % PH;
    we = 1'b0; addr = 0; wd = 1'b0; bcv = 0; ex = 1'b0;
    if (j < N) begin
      we = 1'b1; addr = j; wd = p[0];
    end else begin
      k = j - N; bcv = k / (2*N); m = k % (2*N);
      if (m == 0) begin
        we = 1'b1; addr = bcv; wd = ~p[0];
      end else if (m == 2*N-1) begin
        we = 1'b1; addr = bcv; wd = p[0];
      end else begin
        r = m - 1; pr = r / 2;
        if (r % 2 == 0) begin addr = bcv; ex = ~p[0]; end
        else begin addr = (pr < bcv) ? pr : pr + 1; ex = p[0]; end
      end
    end
  endtask

  task automatic first_fail(input bit fe, input int fa, input bit fv,
                            output bit found, output int faddr,
                            output int fbase, output bit fexp);
    bit m [N];
    bit we, wd, ex, rv;
    int addr, bcv;
    found = 1'b0; faddr = 0; fbase = 0; fexp = 1'b0;
    for (int a = 0; a < N; a++) m[a] = 1'b0;
    for (int i = 0; i < K; i++) begin
      decode_op(i, we, addr, wd, bcv, ex);
      if (we) begin
        if (!(fe && addr == fa)) m[addr] = wd;
      end else begin
        rv = (fe && addr == fa) ? fv : m[addr];
        if (rv != ex && !found) begin
          found = 1'b1; faddr = addr; fbase = bcv; fexp = ex;
        end
      end
    end
  endtask

  task automatic run(input bit fe, input int fa, input bit fv, input bit mid_start);
    int  idx, cnt;
    int  e2, e3, e4;
    bit  we, wd, ex, found, fexp, bad;
    int  addr, bcv, faddr, fbase;
    flt_en = fe; flt_addr = fa; flt_val = fv;
    first_fail(fe, fa, fv, found, faddr, fbase, fexp);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0; cnt = 0; e2 = 0; e3 = 0; e4 = 0;
    while (!done && cnt <= K + 20) begin
      if (idx < K) begin
        decode_op(idx, we, addr, wd, bcv, ex);
        bad = (mem_we != we) || (int'(mem_addr) != addr) || (we && mem_wdata != wd);
        if (bad) begin
          if (idx < N) e2++;
          else if (idx < PH) e3++;
          else e4++;
        end
      end
      idx++;
      start = (mid_start && idx == 37);
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk(e2 == 0, "R2", "fill op mismatches", e2, 0);
    chk(e3 == 0, "R3", "bg0 gallop op mismatches", e3, 0);
    chk(e4 == 0, "R4", "bg1 gallop op mismatches", e4, 0);
    chk(cnt == K, mid_start ? "R8" : "R5", "cycles to done", cnt, K);
    chk(done == 1'b1, "R5", "done", done, 1);
    chk(pass == !found, "R6", "pass at done", pass, !found);
    chk(fail == found, "R7", "fail flag", fail, found);
    if (found) begin
      chk(int'(fail_addr) == faddr, "R7", "fail_addr", fail_addr, faddr);
      chk(int'(fail_base) == fbase, "R7", "fail_base", fail_base, fbase);
      chk(fail_exp == fexp, "R7", "fail_exp", fail_exp, fexp);
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R5", "done/busy after pulse", {done, busy}, 0);
    chk(mem_we == 1'b0, "R9", "we while idle", mem_we, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && pass == 0, "R1", "busy/done/pass in reset", {busy, done, pass}, 0);
    chk(fail == 0 && mem_we == 0, "R1", "fail/we in reset", {fail, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mem_we == 0, "R9", "idle after reset", {busy, mem_we}, 0);
    run(1'b0, 0, 1'b0, 1'b0);          // R6 clean array
    run(1'b1, 0, 1'b0, 1'b0);          // R7 stuck-0 at address 0
    run(1'b1, N-1, 1'b1, 1'b0);        // R7 stuck-1 at last address
    run(1'b0, 0, 1'b0, 1'b1);          // R8 clean run after fail, start mid-run
    for (int t = 0; t < 6; t++) begin
      a = int'($urandom_range(N-1, 0));
      run(1'b1, a, 1'($urandom_range(1, 0)), t[0]);
    end
    run(1'b0, 0, 1'b0, 1'b0);          // R8 start while idle clears result
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule